// File: doc/BRIEF.md
# Protocol Discovery Responder

This block answers the discovery exchange of a mailbox endpoint. A requester learns which (vendor ID, object type) pairs the endpoint speaks by sending single-dword requests that carry an 8-bit entry index. Each reply is a single dword that names the pair stored at that index and gives the index of the next entry. The requester starts at index 0 and follows the next-index values until it reads 0, which ends the chain.

Entry 0 always describes discovery itself: the standards-body vendor ID with object type 0. The other entries come from a packed parameter. The block sits behind the mailbox's object parser. The parser presents one request dword for one cycle with a valid strobe. The reply appears on a registered output, strobed one cycle later, and holds its value until the next request.

Top module: `disc_responder`

## Requirements
- R1: While reset is high and after it is released, `rsp_valid` is 0 and `rsp_data` is 0 until the first request is accepted.
- R2: A request is accepted in every cycle where `req_valid` is 1. `rsp_valid` is 1 in exactly the cycle after each accepted request and 0 otherwise.
- R3: The request index is `req_data[7:0]`. The reply packs the vendor ID in `rsp_data[15:0]`, the object type in `[23:16]` and the next index in `[31:24]`. Index 0 always returns vendor `STD_VID` with type 0.
- R4: An index k with 1 <= k < `N_ENT` returns the pair that the parameter `EXTRA_PROTS` holds for entry k. Entry k sits in bits `[(k-1)*24 +: 24]`, with the vendor ID in the low 16 bits and the type in the top 8 bits.
- R5: For an index k < `N_ENT`-1, the next index is k+1. Following the chain from index 0 visits every entry once.
- R6: The last entry (index `N_ENT`-1) returns next index 0.
- R7: An index of `N_ENT` or above returns the discovery pair with next index 0.
- R8: The version field `req_data[15:8]` and the bits `req_data[31:16]` have no effect on the reply.
- R9: While `rsp_valid` is 0, `rsp_data` keeps the value of the last reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request dword present this cycle |
| req_data | input | 32 | Request payload: index in [7:0], version in [15:8] |
| rsp_valid | output | 1 | Reply dword valid this cycle |
| rsp_data | output | 32 | Reply payload: vendor ID, type, next index |

## Verification
The checker watches five behaviours on every cycle. It checks the one-cycle reply strobe, and that the output data holds between replies. For every request whose index is 0, it checks the discovery pair. For every index inside the table it checks the increment rule, and for every index past the table it checks the terminating reply. Only the bench scenarios can show that each configured table entry is returned correctly and that the version and reserved bits leave the reply unchanged. They also show that a walk from index 0 ends after exactly `N_ENT` replies, and that reset clears the output.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam int DWORD_W = 32;
  localparam int VID_W   = 16;
  localparam int TYPE_W  = 8;
  localparam int IDX_W   = 8;
  localparam int ENTRY_W = VID_W + TYPE_W;

  // Reply dword layout, most significant field first
  typedef struct packed {
    logic [IDX_W-1:0]  next_idx;
    logic [TYPE_W-1:0] ptype;
    logic [VID_W-1:0]  vid;
  } rsp_word_t;

  // Request dword layout, most significant field first
  typedef struct packed {
    logic [DWORD_W-2*IDX_W-1:0] rsvd;
    logic [IDX_W-1:0]           version;
    logic [IDX_W-1:0]           index;
  } req_word_t;
endpackage

// File: rtl/disc_table.sv
module disc_table
  import disc_pkg::*;
#(
  parameter int                      N_ENT       = 4,
  parameter logic [VID_W-1:0]        STD_VID     = 16'h0001,
  parameter logic [(N_ENT-1)*ENTRY_W-1:0] EXTRA_PROTS = '0
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [VID_W-1:0]  vid,
  output logic [TYPE_W-1:0] ptype
);
  localparam int SEL_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

  logic [VID_W-1:0]  vid_rom  [N_ENT];
  logic [TYPE_W-1:0] type_rom [N_ENT];

  generate
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      if (g == 0) begin : g_disc
        assign vid_rom[g]  = STD_VID;
        assign type_rom[g] = '0;
      end else begin : g_cfg
        assign vid_rom[g]  = EXTRA_PROTS[(g-1)*ENTRY_W +: VID_W];
        assign type_rom[g] = EXTRA_PROTS[(g-1)*ENTRY_W+VID_W +: TYPE_W];
      end
    end
  endgenerate

  logic             in_range;
  logic [SEL_W-1:0] sel;

  always_comb begin
    in_range = (idx <= LAST_IDX);
    sel      = in_range ? idx[SEL_W-1:0] : '0;
    vid      = vid_rom[sel];
    ptype    = type_rom[sel];
  end
endmodule

// File: rtl/disc_next.sv
module disc_next
  import disc_pkg::*;
#(
  parameter int N_ENT = 4
) (
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] next_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

  always_comb begin
    if (idx < LAST_IDX) next_idx = idx + IDX_W'(1);
    else                next_idx = '0;
  end
endmodule

// File: rtl/disc_rsp_reg.sv
module disc_rsp_reg
  import disc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  rsp_word_t          word_in,
  output logic               valid_q,
  output logic [DWORD_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= load;
      if (load) data_q <= word_in;
    end
  end
endmodule

// File: rtl/disc_responder.sv
module disc_responder
  import disc_pkg::*;
#(
  parameter int                           N_ENT       = 4,
  parameter logic [VID_W-1:0]             STD_VID     = 16'h0001,
  parameter logic [(N_ENT-1)*ENTRY_W-1:0] EXTRA_PROTS = 72'h00ABCD_021E98_010001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [31:0] req_data,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);
  req_word_t req;
  rsp_word_t word;
  logic      req_unused;

  assign req        = req_data;
  assign req_unused = ^{req.rsvd, req.version};

  disc_table #(
    .N_ENT      (N_ENT),
    .STD_VID    (STD_VID),
    .EXTRA_PROTS(EXTRA_PROTS)
  ) u_table (
    .idx  (req.index),
    .vid  (word.vid),
    .ptype(word.ptype)
  );

  disc_next #(
    .N_ENT(N_ENT)
  ) u_next (
    .idx     (req.index),
    .next_idx(word.next_idx)
  );

  disc_rsp_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .load   (req_valid),
    .word_in(word),
    .valid_q(rsp_valid),
    .data_q (rsp_data)
  );
endmodule

// File: rtl/disc_responder_chk.sv
module disc_responder_chk #(
  parameter int          N_ENT   = 4,
  parameter logic [15:0] STD_VID = 16'h0001
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_data,
  input logic        rsp_valid,
  input logic [31:0] rsp_data
);
  localparam logic [7:0] LAST = 8'(N_ENT - 1);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);                                          // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);                                        // R2
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> $stable(rsp_data));                                 // R9
  AST_DISC_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_data[7:0] == 8'd0) |=>
      (rsp_data[15:0] == STD_VID && rsp_data[23:16] == 8'd0));        // R3
  AST_NEXT_STEP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_data[7:0] < LAST) |=>
      (rsp_data[31:24] == $past(req_data[7:0]) + 8'd1));              // R5
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_data[7:0] == LAST) |=> (rsp_data[31:24] == 8'd0)); // R6
  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_data[7:0] > LAST) |=>
      (rsp_data == {8'd0, 8'd0, STD_VID}));                            // R7
endmodule

bind disc_responder disc_responder_chk #(
  .N_ENT  (N_ENT),
  .STD_VID(STD_VID)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_data (req_data),
  .rsp_valid(rsp_valid),
  .rsp_data (rsp_data)
);

// File: tb/disc_responder_bench.sv
`timescale 1ns/1ps
module disc_responder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  disc_responder u_disc_responder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // {request dword, expected reply dword}; table: 0 disc, 1 {01,0001}, 2 {02,1E98}, 3 {00,ABCD}
  localparam logic [63:0] VEC [10] = '{
    {32'h0000_0000, 32'h0100_0001},  // R3 index 0
    {32'h0000_0001, 32'h0201_0001},  // R4 R5 index 1
    {32'h0000_0002, 32'h0302_1E98},  // R4 R5 index 2
    {32'h0000_0003, 32'h0000_ABCD},  // R4 R6 last entry
    {32'h0000_0004, 32'h0000_0001},  // R7 just past table
    {32'h0000_00FF, 32'h0000_0001},  // R7 largest index
    {32'h0000_0201, 32'h0201_0001},  // R8 version 2
    {32'hFFFF_0002, 32'h0302_1E98},  // R8 reserved bits set
    {32'h0000_FF03, 32'h0000_ABCD},  // R8 odd version
    {32'hA5A5_0200, 32'h0100_0001}   // R8 discovery with junk
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request, return reply sampled one clock later
  task automatic xfer(input logic [31:0] d, output logic v, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1;
    req_data  = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_data  = '0;
    v = rsp_valid;
    r = rsp_data;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic        v;
    logic [31:0] r;
    logic [31:0] prev;
    logic [7:0]  idx;
    int          count;

    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, rsp_valid}, 32'd0);
    check("R1 data in reset", rsp_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R1 data after reset", rsp_data, 32'd0);

    for (int i = 0; i < 10; i++) begin
      xfer(VEC[i][63:32], v, r);
      check("R2 strobe", {31'd0, v}, 32'd1);
      check("R3-R8 vector reply", r, VEC[i][31:0]);
      @(negedge clk);
      check("R2 single pulse", {31'd0, rsp_valid}, 32'd0);
      check("R9 held data", rsp_data, VEC[i][31:0]);
    end

    // R5 R6: chain walk from 0
    idx = 8'd0; count = 0;
    for (int k = 0; k < 8; k++) begin
      xfer({24'd0, idx}, v, r);
      count++;
      if (r[31:24] != 8'd0) check("R5 next increments", {24'd0, r[31:24]}, {24'd0, idx + 8'd1});
      idx = r[31:24];
      if (idx == 8'd0) break;
    end
    check("R6 chain length", count, 4);

    // R2 back to back requests
    @(negedge clk);
    req_valid = 1'b1; req_data = 32'h0000_0002;
    @(negedge clk);
    check("R2 first of pair", rsp_data, 32'h0302_1E98);
    req_data = 32'h0000_0009;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 second of pair valid", {31'd0, rsp_valid}, 32'd1);
    check("R7 second of pair", rsp_data, 32'h0000_0001);
    prev = rsp_data;
    repeat (3) @(negedge clk);
    check("R9 idle hold", rsp_data, prev);

    // R1 reset in mid-stream
    xfer(32'h0000_0003, v, r);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 cleared by reset", rsp_data, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule